// File: doc/BRIEF.md
# Triggered Conversion Queue Sequencer

This block walks a small table of conversion commands and hands them one at a time to a converter. Each command names a converter channel and may carry a pause mark. For every command it raises a one-cycle start strobe with the channel number and then waits for the converter's done pulse. The queue ends at a reserved end code or at the last table slot, whichever comes first. A register keeps the index of the last command that was actually converted.

Two scan modes drive it. In gated mode the queue runs while an external gate is high. The gate is looked at only when a conversion finishes. A low gate at that point aborts the pass and raises a sticky incomplete flag. The next rising gate starts again from slot 0. In timed mode a 17-stage interval counter, clocked by a prescaled conversion tick, triggers a pass every 2^(7+sel) ticks. A pause command holds the queue until the next trigger. A trigger that lands while a command is being issued or converted sets a sticky overrun flag.

The completion, overrun and incomplete flags stay set until a write-one-to-clear strobe removes them. The completion flag drives the interrupt output when the interrupt is enabled.

Top module: `scan_queue_sequencer`

## Requirements
- R1: With mode_sel = 2'b01 (gated) and the gate high, commands are issued in table order starting at slot 0. Each issue is a single-cycle conv_start with conv_chan equal to that slot's channel. mode_sel values 2'b00 and 2'b11 keep the block idle.
- R2: The gate is sampled only in the cycle conv_done is seen. A low gate that is high again before conv_done does not stop the queue.
- R3: If the gate is low when conv_done arrives for a command that is not the end of the queue, execution stops, the incomplete flag is set and last_ptr holds that command's slot index.
- R4: After an abort, the next high gate restarts execution at slot 0.
- R5: The queue ends at a command whose channel is 63 (that command is not converted) or after converting the last slot. Either way the completion flag is set, and last_ptr is the slot of the last converted command.
- R6: With mode_sel = 2'b10 (timed), the conversion tick occurs every prescale+1 clocks. A trigger fires every 2^(7+interval_sel) ticks, with interval_sel limited to 10. The counter starts from zero when timed mode is entered, so with prescale 0 the first conv_start is seen 128·2^interval_sel clocks later.
- R7: In timed mode, after a command with the pause bit set is converted, the queue waits for the next trigger and then issues the following slot. In gated mode the pause bit has no effect.
- R8: In timed mode, the first trigger after the end of the queue starts execution again at slot 0.
- R9: A trigger arriving while a command is being issued or converted sets the overrun flag. A trigger that arrives while paused or idle does not.
- R10: The flags are sticky. clr_flags bit 0 clears completion, bit 1 clears overrun and bit 2 clears incomplete. A flag being set in the same cycle as its clear bit ends up set.
- R11: irq equals the completion flag ANDed with irq_en.
- R12: After reset all flags, irq, conv_start and last_ptr are zero, and every table slot holds the end code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 00 off, 01 gated scan, 10 timed scan, 11 off |
| gate | input | 1 | External gate for gated scan |
| interval_sel | input | 4 | Timer interval exponent offset (interval 2^(7+sel) ticks, sel limited to 10) |
| prescale | input | PRE_W | Conversion tick every prescale+1 clocks |
| tbl_we | input | 1 | Command table write strobe |
| tbl_addr | input | AW | Command table slot to write |
| tbl_pause | input | 1 | Pause bit of the written command |
| tbl_chan | input | 6 | Channel of the written command (63 = end of queue) |
| irq_en | input | 1 | Completion interrupt enable |
| clr_flags | input | 3 | Write-one-to-clear: [0] completion, [1] overrun, [2] incomplete |
| conv_done | input | 1 | Converter finished the current command |
| conv_start | output | 1 | One-cycle request to convert conv_chan |
| conv_chan | output | 6 | Channel of the command being issued |
| flag_incomplete | output | 1 | Sticky: gated pass aborted |
| flag_overrun | output | 1 | Sticky: trigger while executing |
| flag_complete | output | 1 | Sticky: end of queue reached |
| last_ptr | output | AW | Slot index of the last converted command |
| irq | output | 1 | Completion interrupt |

## Verification
The main coincidence is a flag being set and being cleared in the same cycle. The incomplete flag is set by a converter done pulse that arrives while the gate is low, and the clear strobe can fall on that same cycle. The bench drives conv_done and clr_flags[2] on the same clock itself, so the collision happens on a known cycle. It then expects the flag to stay set, and to drop only on a later clear on its own. A second coincidence comes from making the converter slower than the timer interval, so that a trigger lands during a conversion. That case must show up as overrun and not as a restart.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int CHAN_W      = 6;
    localparam logic [CHAN_W-1:0] END_CODE = '1;
    localparam int INT_STAGES  = 17;
    localparam int INT_MIN_LOG = 7;
    localparam int INT_SEL_MAX = 10;

    typedef struct packed {
        logic              pause;
        logic [CHAN_W-1:0] chan;
    } cmd_t;

    typedef enum logic [1:0] {
        SCAN_OFF   = 2'b00,
        SCAN_GATED = 2'b01,
        SCAN_TIMED = 2'b10
    } scan_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_HOLD
    } seq_state_e;

    typedef struct packed {
        logic incomplete;
        logic overrun;
        logic complete;
    } flags_t;

    // Terminal count of the interval counter for a given selector.
    function automatic logic [INT_STAGES-1:0] interval_last(input logic [3:0] sel);
        int s;
        s = (int'(sel) > INT_SEL_MAX) ? INT_SEL_MAX : int'(sel);
        return INT_STAGES'((1 << (INT_MIN_LOG + s)) - 1);
    endfunction

endpackage

// File: rtl/qclk_divider.sv
module qclk_divider #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt;

    assign tick = (pcnt >= prescale);

    always_ff @(posedge clk) begin
        if (rst || tick) pcnt <= '0;
        else             pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/interval_timer.sv
module interval_timer import scan_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       tick,
    input  logic [3:0] sel,
    output logic       trig
);
    logic [INT_STAGES-1:0] cnt;
    logic [INT_STAGES-1:0] last;

    assign last = interval_last(sel);
    assign trig = run && tick && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (trig)    cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/scan_queue_fsm.sv
module scan_queue_fsm import scan_pkg::*; #(
    parameter  int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  scan_mode_e    mode,
    input  logic          gate,
    input  logic          trig,
    input  logic          conv_done,
    input  cmd_t          cmd,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] last_ptr,
    output logic          conv_start,
    output flags_t        set_flags
);
    seq_state_e state;
    logic gated, timed, is_end, at_last, finishing;

    assign gated     = (mode == SCAN_GATED);
    assign timed     = (mode == SCAN_TIMED);
    assign is_end    = (cmd.chan == END_CODE);
    assign at_last   = (ptr == AW'(DEPTH - 1));
    assign finishing = (state == ST_WAIT) && conv_done;

    assign conv_start = (state == ST_ISSUE) && !is_end;

    always_comb begin
        set_flags            = '0;
        set_flags.complete   = (gated || timed) &&
                               (((state == ST_ISSUE) && is_end) || (finishing && at_last));
        set_flags.incomplete = gated && finishing && !at_last && !gate;
        set_flags.overrun    = trig && ((state == ST_ISSUE) || (state == ST_WAIT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ptr      <= '0;
            last_ptr <= '0;
        end else if (!(gated || timed)) begin
            state <= ST_IDLE;
            ptr   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if ((gated && gate) || (timed && trig)) begin
                    ptr   <= '0;
                    state <= ST_ISSUE;
                end
                ST_ISSUE: state <= is_end ? ST_IDLE : ST_WAIT;
                ST_WAIT: if (conv_done) begin
                    last_ptr <= ptr;
                    if (at_last)                  state <= ST_IDLE;
                    else if (timed && cmd.pause)  state <= ST_HOLD;
                    else if (gated && !gate)      state <= ST_IDLE;
                    else begin
                        ptr   <= ptr + 1'b1;
                        state <= ST_ISSUE;
                    end
                end
                ST_HOLD: if (!timed) begin
                    state <= ST_IDLE;
                end else if (trig) begin
                    ptr   <= ptr + 1'b1;
                    state <= ST_ISSUE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/scan_queue_sequencer.sv
module scan_queue_sequencer import scan_pkg::*; #(
    parameter  int DEPTH = 8,
    parameter  int PRE_W = 4,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              gate,
    input  logic [3:0]        interval_sel,
    input  logic [PRE_W-1:0]  prescale,
    input  logic              tbl_we,
    input  logic [AW-1:0]     tbl_addr,
    input  logic              tbl_pause,
    input  logic [CHAN_W-1:0] tbl_chan,
    input  logic              irq_en,
    input  logic [2:0]        clr_flags,
    input  logic              conv_done,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              flag_incomplete,
    output logic              flag_overrun,
    output logic              flag_complete,
    output logic [AW-1:0]     last_ptr,
    output logic              irq
);
    scan_mode_e mode;
    logic       tick, trig;
    logic [AW-1:0] ptr;
    cmd_t       table_q [DEPTH];
    cmd_t       cur_cmd;
    flags_t     set_flags, flags_q, clr_vec;

    assign mode    = scan_mode_e'(mode_sel);
    assign cur_cmd = table_q[ptr];
    assign clr_vec = flags_t'(clr_flags);

    qclk_divider #(.PRE_W(PRE_W)) u_div (
        .clk(clk), .rst(rst), .prescale(prescale), .tick(tick)
    );

    interval_timer u_timer (
        .clk(clk), .rst(rst), .run(mode == SCAN_TIMED),
        .tick(tick), .sel(interval_sel), .trig(trig)
    );

    scan_queue_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk(clk), .rst(rst), .mode(mode), .gate(gate), .trig(trig),
        .conv_done(conv_done), .cmd(cur_cmd), .ptr(ptr),
        .last_ptr(last_ptr), .conv_start(conv_start), .set_flags(set_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) table_q[i] <= '{pause: 1'b0, chan: END_CODE};
        end else if (tbl_we) begin
            table_q[tbl_addr] <= '{pause: tbl_pause, chan: tbl_chan};
        end
    end

    // Set has priority over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= set_flags | (flags_q & ~clr_vec);
    end

    assign conv_chan       = cur_cmd.chan;
    assign flag_incomplete = flags_q.incomplete;
    assign flag_overrun    = flags_q.overrun;
    assign flag_complete   = flags_q.complete;
    assign irq             = flags_q.complete & irq_en;
endmodule

// File: rtl/scan_queue_sequencer_checker.sv
module scan_queue_sequencer_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_sel,
    input logic [2:0] clr_flags,
    input logic       irq_en,
    input logic       conv_start,
    input logic       flag_incomplete,
    input logic       flag_overrun,
    input logic       flag_complete,
    input logic       irq
);
    assert_reset_clear_R12: assert property (@(posedge clk)
        rst |=> (!flag_complete && !flag_overrun && !flag_incomplete && !conv_start));

    assert_irq_enable_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_en);

    assert_complete_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (flag_complete && !clr_flags[0]) |=> flag_complete);

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (flag_overrun && !clr_flags[1]) |=> flag_overrun);

    assert_incomplete_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (flag_incomplete && !clr_flags[2]) |=> flag_incomplete);

    assert_start_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b00 && $past(mode_sel) == 2'b00) |-> !conv_start);
endmodule

bind scan_queue_sequencer scan_queue_sequencer_checker u_chk (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .clr_flags(clr_flags),
    .irq_en(irq_en), .conv_start(conv_start), .flag_incomplete(flag_incomplete),
    .flag_overrun(flag_overrun), .flag_complete(flag_complete), .irq(irq)
);

// File: tb/test_scan_queue_sequencer.sv
module test_scan_queue_sequencer;
    localparam int DEPTH = 8;
    localparam int AW    = 3;
    localparam int ENDC  = 63;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic gate = 1'b0;
    logic [3:0] interval_sel = 4'd0;
    logic [3:0] prescale = 4'd0;
    logic tbl_we = 1'b0;
    logic [AW-1:0] tbl_addr = '0;
    logic tbl_pause = 1'b0;
    logic [5:0] tbl_chan = '0;
    logic irq_en = 1'b0;
    logic [2:0] clr_flags = 3'b000;
    logic conv_done = 1'b0;
    logic conv_start;
    logic [5:0] conv_chan;
    logic flag_incomplete, flag_overrun, flag_complete, irq;
    logic [AW-1:0] last_ptr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int lat = 3;
    bit auto_done = 1'b1;
    int log_chan [512];
    int log_cyc  [512];
    int n_log = 0;

    scan_queue_sequencer #(.DEPTH(DEPTH), .PRE_W(4)) i_scan_queue_sequencer (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .gate(gate),
        .interval_sel(interval_sel), .prescale(prescale), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_pause(tbl_pause), .tbl_chan(tbl_chan),
        .irq_en(irq_en), .clr_flags(clr_flags), .conv_done(conv_done),
        .conv_start(conv_start), .conv_chan(conv_chan),
        .flag_incomplete(flag_incomplete), .flag_overrun(flag_overrun),
        .flag_complete(flag_complete), .last_ptr(last_ptr), .irq(irq)
    );

    always #2 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // Issue log
    initial forever begin
        @(negedge clk);
        if (conv_start && n_log < 512) begin
            log_chan[n_log] = int'(conv_chan);
            log_cyc[n_log]  = cyc;
            n_log++;
        end
    end

    // Converter stand-in
    initial forever begin
        if (conv_start && auto_done) begin
            repeat (lat) @(negedge clk);
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
        end else begin
            @(negedge clk);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input int idx, input bit p, input int ch);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = AW'(idx); tbl_pause = p; tbl_chan = 6'(ch);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_flags = 3'b111;
        @(negedge clk);
        clr_flags = 3'b000;
    endtask

    task automatic go_off();
        @(negedge clk);
        mode_sel = 2'b00; gate = 1'b0;
        cycles(lat + 4);
        n_log = 0;
    endtask

    task automatic gated_pass_until_complete(input int limit);
        gate = 1'b1; mode_sel = 2'b01;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (flag_complete) break;
        end
        gate = 1'b0;
        cycles(lat + 4);
    endtask

    function automatic int nth_start(input int ch, input int n);
        int k = 0;
        for (int i = 0; i < n_log; i++) begin
            if (log_chan[i] == ch) begin
                if (k == n) return log_cyc[i];
                k++;
            end
        end
        return -1;
    endfunction

    task automatic t_reset();
        check("R12 flag_complete after reset", int'(flag_complete), 0);
        check("R12 flag_overrun after reset", int'(flag_overrun), 0);
        check("R12 flag_incomplete after reset", int'(flag_incomplete), 0);
        check("R12 conv_start after reset", int'(conv_start), 0);
        check("R12 last_ptr after reset", int'(last_ptr), 0);
        check("R12 irq after reset", int'(irq), 0);
        // Empty table holds end code: a gated pass converts nothing
        gated_pass_until_complete(50);
        check("R12 reset table is all end codes", n_log, 0);
        check("R12 end-only queue completes", int'(flag_complete), 1);
        go_off();
        clear_all();
    endtask

    task automatic t_gated_full();
        load(0, 1'b1, 5); load(1, 1'b0, 6); load(2, 1'b0, 7); load(3, 1'b0, 8); load(4, 1'b0, ENDC);
        n_log = 0;
        gated_pass_until_complete(200);
        check("R1 gated pass issue count", n_log, 4);
        check("R1 first channel", log_chan[0], 5);
        check("R7 pause ignored in gated mode, channel 6 follows", log_chan[1], 6);
        check("R1 fourth channel", log_chan[3], 8);
        check("R5 end code completes", int'(flag_complete), 1);
        check("R5 last_ptr at last converted slot", int'(last_ptr), 3);
        check("R11 irq low with enable off", int'(irq), 0);
        @(negedge clk); irq_en = 1'b1; #1;
        check("R11 irq follows flag when enabled", int'(irq), 1);
        @(negedge clk); clr_flags = 3'b001;
        @(negedge clk); clr_flags = 3'b000;
        check("R10 completion cleared by bit 0", int'(flag_complete), 0);
        check("R11 irq drops with flag", int'(irq), 0);
        irq_en = 1'b0;
        go_off();
    endtask

    task automatic t_gate_stop_and_restart();
        gate = 1'b1; mode_sel = 2'b01;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (conv_start && conv_chan == 6'd6) break;
        end
        gate = 1'b0;
        cycles(lat + 6);
        check("R3 stop sets incomplete", int'(flag_incomplete), 1);
        check("R3 no completion on abort", int'(flag_complete), 0);
        check("R3 last_ptr at aborted slot", int'(last_ptr), 1);
        check("R3 no issue after abort", n_log, 2);
        n_log = 0;
        gated_pass_until_complete(200);
        check("R4 restart begins at slot 0", log_chan[0], 5);
        check("R4 full pass after restart", n_log, 4);
        go_off();
        clear_all();
    endtask

    task automatic t_gate_glitch();
        gate = 1'b1; mode_sel = 2'b01;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (conv_start && conv_chan == 6'd6) break;
        end
        gate = 1'b0;
        @(negedge clk);
        gate = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (flag_complete) break;
        end
        gate = 1'b0;
        cycles(lat + 4);
        check("R2 short low gate missed, full pass", n_log, 4);
        check("R2 no incomplete flag", int'(flag_incomplete), 0);
        go_off();
        clear_all();
    endtask

    task automatic t_last_slot_end();
        load(4, 1'b0, 20); load(5, 1'b0, 21); load(6, 1'b0, 22); load(7, 1'b0, 23);
        n_log = 0;
        gated_pass_until_complete(300);
        check("R5 last slot ends queue, issue count", n_log, 8);
        check("R5 last slot channel", log_chan[7], 23);
        check("R5 last_ptr at final slot", int'(last_ptr), 7);
        check("R5 completion on last slot", int'(flag_complete), 1);
        go_off();
        clear_all();
    endtask

    task automatic run_timed(input int pre, input int sel, input int n30, input int limit, output int c0);
        @(negedge clk);
        prescale = 4'(pre); interval_sel = 4'(sel);
        n_log = 0;
        mode_sel = 2'b10;
        c0 = cyc;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (nth_start(30, n30 - 1) >= 0) break;
        end
        cycles(lat + 4);
    endtask

    task automatic t_timed();
        int c0;
        load(0, 1'b0, 30); load(1, 1'b0, 31); load(2, 1'b0, ENDC);
        run_timed(0, 0, 3, 1000, c0);
        check("R6 first trigger after 128 clocks", nth_start(30, 0) - c0, 128);
        check("R6 interval 128 clocks", nth_start(30, 1) - nth_start(30, 0), 128);
        check("R8 restart at slot 0 after end", nth_start(30, 2) - nth_start(30, 1), 128);
        check("R8 slot 1 ran between passes", int'(nth_start(31, 1) > nth_start(30, 1)), 1);
        check("R9 no overrun with short queue", int'(flag_overrun), 0);
        go_off();
        run_timed(1, 0, 2, 2000, c0);
        check("R6 prescale 1 doubles interval", nth_start(30, 1) - nth_start(30, 0), 256);
        go_off();
        run_timed(1, 2, 2, 5000, c0);
        check("R6 sel 2 prescale 1 interval", nth_start(30, 1) - nth_start(30, 0), 1024);
        go_off();
        prescale = 4'd0; interval_sel = 4'd0;
        clear_all();
    endtask

    task automatic t_pause();
        int c0;
        load(0, 1'b1, 30); load(1, 1'b0, 31); load(2, 1'b0, ENDC);
        run_timed(0, 0, 2, 1000, c0);
        check("R7 paused slot waits one interval", nth_start(31, 0) - nth_start(30, 0), 128);
        check("R8 next pass one interval after resume", nth_start(30, 1) - nth_start(31, 0), 128);
        check("R9 trigger while paused is no overrun", int'(flag_overrun), 0);
        go_off();
        clear_all();
    endtask

    task automatic t_overrun();
        int c0;
        load(0, 1'b0, 30); load(1, 1'b0, ENDC);
        lat = 200;
        run_timed(0, 0, 1, 1000, c0);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (flag_overrun) break;
        end
        check("R9 trigger during conversion sets overrun", int'(flag_overrun), 1);
        go_off();
        cycles(220);
        lat = 3;
        @(negedge clk); clr_flags = 3'b010;
        @(negedge clk); clr_flags = 3'b000;
        check("R10 overrun cleared by bit 1", int'(flag_overrun), 0);
        clear_all();
    endtask

    task automatic t_set_clear_collision();
        load(0, 1'b0, 40); load(1, 1'b0, 41); load(2, 1'b0, ENDC);
        auto_done = 1'b0;
        @(negedge clk);
        gate = 1'b1; mode_sel = 2'b01;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (conv_start) break;
        end
        gate = 1'b0;
        @(negedge clk);
        conv_done = 1'b1; clr_flags = 3'b100;
        @(negedge clk);
        conv_done = 1'b0; clr_flags = 3'b000;
        check("R10 set wins over same-cycle clear", int'(flag_incomplete), 1);
        check("R3 last_ptr at slot 0", int'(last_ptr), 0);
        @(negedge clk); clr_flags = 3'b100;
        @(negedge clk); clr_flags = 3'b000;
        check("R10 incomplete cleared by bit 2", int'(flag_incomplete), 0);
        auto_done = 1'b1;
        go_off();
    endtask

    initial begin
        cycles(4);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_gated_full();
        t_gate_stop_and_restart();
        t_gate_glitch();
        t_last_slot_end();
        t_timed();
        t_pause();
        t_overrun();
        t_set_clear_collision();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule